// File: doc/BRIEF.md
# I2C Message Sequencer

This block runs one whole I2C read or write message on top of a byte-level bus master controller. That controller reports its progress as an 8-bit status code and raises a flag each time a bus step completes. The sequencer takes a one-cycle `go` request with the target address, an address-width flag (7 or 10 bits), a direction and a byte count. It then drives the controller's control and data registers to produce the message: START, one or two address bytes, the data bytes, and STOP. Outgoing bytes are pulled from a transmit stream. Incoming bytes are pushed onto a receive stream.

The next step is always chosen from the status code that the controller reports on the rising edge of its flag. A zero-length read acts as a presence probe. The acknowledge-enable bit is dropped before the last read byte, so the controller answers that byte with NACK. An abort request finishes the message early. A missing device and an unexpected status are both reported through `err` when `done` pulses. On an unexpected status the controller is also reinitialised.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: With `msg_ten`=0, status 0x08 or 0x10 makes the sequencer load the data register with {addr[6:0], dir}, where dir=1 means read. A control write with the current control value accompanies this load.
- R2: With `msg_ten`=1, status 0x08/0x10 loads 0xF0 | (addr[9:8]<<1) | dir. A following status 0x18 (write) or 0x40 (read) loads addr[7:0].
- R3: An accepted `go` emits a control write of enable (bit 6) + ACK-enable (bit 2) + START (bit 5), plus interrupt-enable (bit 7) when USE_IRQ=1. The value is 0xE4 by default. `busy` rises after this write.
- R4: On a write, status 0x18 (7-bit), 0xD0 or 0x28 with bytes remaining pulses `tx_take`, loads `tx_data` into the data register and writes the control value without STOP.
- R5: On a write with no bytes remaining, the sequencer writes a control value with STOP (bit 4) set and interrupt-enable cleared (0x54 by default). `done` pulses with `err`=0 (none) and `busy` falls.
- R6: An abort pending on a write ends the message with STOP only after at least one data byte has been sent. Before the first byte, the abort does not prevent sending.
- R7: On a read, status 0x40 (7-bit) or 0xE0 with a byte count of zero issues STOP and finishes with `err`=0. No byte is received.
- R8: On a read, status 0x40/0xE0 with bytes remaining writes the control value without receiving. Status 0x50 pushes `ctl_rdata` onto `rx_data` and decrements the count. ACK-enable is cleared in that control write once exactly one byte remains.
- R9: Status 0x58 pushes the final byte, issues STOP and finishes with `err`=0.
- R10: Status 0x20, 0x30 or 0x48 issues STOP and finishes with `err`=1 (no device).
- R11: Any other status during a message issues STOP, pulses `ctl_reinit` and finishes with `err`=2 (I/O error).
- R12: A flag rising edge while idle with no latched error is answered with a STOP control write and no `done`.
- R13: Exactly one status event is handled per rising edge of `ctl_iflag`, however long the flag stays high. After an error is latched, events are ignored until the next `go`.
- R14: An abort pending during a read clears ACK-enable in the next read control write, whatever the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start one message (accepted only when idle) |
| msg_addr | input | 10 | Target address (bits 6:0 used in 7-bit mode) |
| msg_ten | input | 1 | 1 selects 10-bit addressing |
| msg_rd | input | 1 | 1 for read, 0 for write |
| msg_len | input | LEN_W | Number of data bytes |
| abort_req | input | 1 | Request early termination (latched while busy) |
| tx_data | input | 8 | Next byte to transmit |
| tx_take | output | 1 | Pulse: `tx_data` consumed |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Pulse: `rx_data` valid |
| ctl_iflag | input | 1 | Controller step-complete flag |
| ctl_status | input | 8 | Controller status code |
| ctl_rdata | input | 8 | Controller data register read value |
| ctl_cmd_valid | output | 1 | Pulse: write `ctl_cmd` to controller control register |
| ctl_cmd | output | 8 | Control value |
| ctl_dat_we | output | 1 | Pulse: write `ctl_dat` to controller data register |
| ctl_dat | output | 8 | Data register value |
| ctl_reinit | output | 1 | Pulse: reinitialise the controller |
| busy | output | 1 | Message in progress |
| done | output | 1 | Pulse: message finished |
| err | output | 2 | Result of last message: 0 none, 1 no device, 2 I/O |

## Verification
The hardest states to reach are those where the sequencer's own history changes how a status code is read. One example is an abort that lands before the first write byte versus after it. Another is a read whose remaining count crosses one while ACK-enable is being managed. A third is a flag edge arriving after an error has been latched. The bench acts as the controller: one task raises the flag with a chosen status and read value, then drops it. Scenario tasks chain these events into status sequences, pulsing `abort_req` between particular events. The flag is also held high for several cycles to show that only one action follows.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
   // control register bit positions decoded by the controller
   localparam int CB_ACK   = 2;
   localparam int CB_STOP  = 4;
   localparam int CB_START = 5;
   localparam int CB_EN    = 6;
   localparam int CB_INTEN = 7;

   localparam logic [7:0] M_ACK   = 8'(1 << CB_ACK);
   localparam logic [7:0] M_STOP  = 8'(1 << CB_STOP);
   localparam logic [7:0] M_START = 8'(1 << CB_START);
   localparam logic [7:0] M_EN    = 8'(1 << CB_EN);
   localparam logic [7:0] M_INTEN = 8'(1 << CB_INTEN);

   // controller status codes
   localparam logic [7:0] ST_START       = 8'h08;
   localparam logic [7:0] ST_RSTART      = 8'h10;
   localparam logic [7:0] ST_WA_ACK      = 8'h18;
   localparam logic [7:0] ST_WA_NACK     = 8'h20;
   localparam logic [7:0] ST_WD_ACK      = 8'h28;
   localparam logic [7:0] ST_WD_NACK     = 8'h30;
   localparam logic [7:0] ST_RA_ACK      = 8'h40;
   localparam logic [7:0] ST_RA_NACK     = 8'h48;
   localparam logic [7:0] ST_RD_ACK      = 8'h50;
   localparam logic [7:0] ST_RD_NACK     = 8'h58;
   localparam logic [7:0] ST_WA2_ACK     = 8'hD0;
   localparam logic [7:0] ST_RA2_ACK     = 8'hE0;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'd0,
      ERR_NODEV = 2'd1,
      ERR_IO    = 2'd2
   } err_e;

   typedef enum logic [3:0] {
      ACT_NONE,
      ACT_ADDR1,
      ACT_ADDR2,
      ACT_WRBYTE,
      ACT_RDCONT,
      ACT_RDBYTE,
      ACT_RDLAST,
      ACT_STOP_OK,
      ACT_STOP_NODEV,
      ACT_STOP_IO,
      ACT_STOP_IDLE
   } act_e;
endpackage

// File: rtl/i2cseq_edge.sv
module i2cseq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   output logic evt
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag;
   end

   assign evt = flag & ~flag_q;

   // R13: a level held high yields a single event
   a_r13_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
endmodule

// File: rtl/i2cseq_addr.sv
module i2cseq_addr #(
   parameter int AW = 10
) (
   input  logic [AW-1:0] addr,
   input  logic          ten,
   input  logic          rd,
   output logic [7:0]    first_b,
   output logic [7:0]    second_b
);
   if (AW != 10) begin : g_bad_aw
      $error("i2cseq_addr: AW must be 10");
   end

   always_comb begin
      if (ten) begin
         first_b  = 8'hF0 | {5'b0, addr[9:8], 1'b0} | {7'b0, rd};
         second_b = addr[7:0];
      end else begin
         first_b  = {addr[6:0], rd};
         second_b = 8'h00;
      end
   end
endmodule

// File: rtl/i2cseq_decode.sv
module i2cseq_decode
   import i2cseq_pkg::*;
(
   input  logic       evt,
   input  logic       busy,
   input  logic       err_lat,
   input  logic [7:0] status,
   input  logic       ten,
   input  logic       rem_zero,
   input  logic       abort_q,
   input  logic       sent,
   output act_e       act
);
   act_e wr_next;
   act_e rd_first;

   assign wr_next  = (rem_zero || (abort_q && sent)) ? ACT_STOP_OK : ACT_WRBYTE;
   assign rd_first = rem_zero ? ACT_STOP_OK : ACT_RDCONT;

   always_comb begin
      act = ACT_NONE;
      if (evt && !err_lat) begin
         if (!busy) begin
            act = ACT_STOP_IDLE;
         end else begin
            unique case (status)
               ST_START, ST_RSTART:          act = ACT_ADDR1;
               ST_WA_ACK:                    act = ten ? ACT_ADDR2 : wr_next;
               ST_WA2_ACK, ST_WD_ACK:        act = wr_next;
               ST_RA_ACK:                    act = ten ? ACT_ADDR2 : rd_first;
               ST_RA2_ACK:                   act = rd_first;
               ST_RD_ACK:                    act = ACT_RDBYTE;
               ST_RD_NACK:                   act = ACT_RDLAST;
               ST_WA_NACK, ST_WD_NACK,
               ST_RA_NACK:                   act = ACT_STOP_NODEV;
               default:                      act = ACT_STOP_IO;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
   import i2cseq_pkg::*;
#(
   parameter int LEN_W   = 8,
   parameter int AW      = 10,
   parameter bit USE_IRQ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [AW-1:0]    msg_addr,
   input  logic             msg_ten,
   input  logic             msg_rd,
   input  logic [LEN_W-1:0] msg_len,
   input  logic             abort_req,
   input  logic [7:0]       tx_data,
   output logic             tx_take,
   output logic [7:0]       rx_data,
   output logic             rx_valid,
   input  logic             ctl_iflag,
   input  logic [7:0]       ctl_status,
   input  logic [7:0]       ctl_rdata,
   output logic             ctl_cmd_valid,
   output logic [7:0]       ctl_cmd,
   output logic             ctl_dat_we,
   output logic [7:0]       ctl_dat,
   output logic             ctl_reinit,
   output logic             busy,
   output logic             done,
   output logic [1:0]       err
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
   localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

   if (LEN_W < 2) begin : g_bad_len
      $error("i2c_msg_sequencer: LEN_W must be at least 2");
   end

   logic [7:0] base_ctrl;
   if (USE_IRQ) begin : g_irq
      assign base_ctrl = M_EN | M_ACK | M_INTEN;
   end else begin : g_poll
      assign base_ctrl = M_EN | M_ACK;
   end

   logic             busy_q, ten_q, rd_q, abort_q, sent_q;
   logic [AW-1:0]    addr_q;
   logic [LEN_W-1:0] rem_q;
   logic [7:0]       ctrl_q;
   err_e             err_q;
   logic             evt;
   act_e             act;
   logic [7:0]       b1, b2;

   i2cseq_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .flag (ctl_iflag),
      .evt  (evt)
   );

   i2cseq_addr #(.AW(AW)) u_addr (
      .addr    (addr_q),
      .ten     (ten_q),
      .rd      (rd_q),
      .first_b (b1),
      .second_b(b2)
   );

   i2cseq_decode u_dec (
      .evt     (evt),
      .busy    (busy_q),
      .err_lat (err_q != ERR_NONE),
      .status  (ctl_status),
      .ten     (ten_q),
      .rem_zero(rem_q == '0),
      .abort_q (abort_q),
      .sent    (sent_q),
      .act     (act)
   );

   logic             ack_drop;
   logic [7:0]       ctrl_rd, ctrl_stop;
   logic [LEN_W-1:0] rem_dec;
   logic             accept;

   assign accept    = go && !busy_q;
   assign rem_dec   = (rem_q == '0) ? rem_q : rem_q - ONE;
   assign ack_drop  = abort_q || (act == ACT_RDCONT && rem_q == ONE)
                              || (act == ACT_RDBYTE && rem_q == TWO);
   assign ctrl_rd   = ack_drop ? (ctrl_q & ~M_ACK) : ctrl_q;
   assign ctrl_stop = (ctrl_q & ~M_INTEN) | M_STOP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;  ten_q <= 1'b0;  rd_q <= 1'b0;
         abort_q <= 1'b0; sent_q <= 1'b0;
         addr_q <= '0;    rem_q <= '0;    ctrl_q <= '0;
         err_q <= ERR_NONE;
         tx_take <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
         ctl_cmd_valid <= 1'b0; ctl_cmd <= '0;
         ctl_dat_we <= 1'b0; ctl_dat <= '0;
         ctl_reinit <= 1'b0; done <= 1'b0;
      end else begin
         tx_take <= 1'b0; rx_valid <= 1'b0; ctl_cmd_valid <= 1'b0;
         ctl_dat_we <= 1'b0; ctl_reinit <= 1'b0; done <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            addr_q <= msg_addr; ten_q <= msg_ten; rd_q <= msg_rd;
            rem_q <= msg_len;   sent_q <= 1'b0;   abort_q <= 1'b0;
            err_q <= ERR_NONE;  ctrl_q <= base_ctrl;
            ctl_cmd_valid <= 1'b1;
            ctl_cmd <= base_ctrl | M_START;
         end else begin
            if (abort_req && busy_q) abort_q <= 1'b1;
            unique case (act)
               ACT_ADDR1, ACT_ADDR2: begin
                  ctl_dat_we <= 1'b1;
                  ctl_dat <= (act == ACT_ADDR1) ? b1 : b2;
                  ctl_cmd_valid <= 1'b1;
                  ctl_cmd <= ctrl_q;
               end
               ACT_WRBYTE: begin
                  tx_take <= 1'b1;
                  ctl_dat_we <= 1'b1;
                  ctl_dat <= tx_data;
                  rem_q <= rem_dec;
                  sent_q <= 1'b1;
                  ctl_cmd_valid <= 1'b1;
                  ctl_cmd <= ctrl_q;
               end
               ACT_RDCONT, ACT_RDBYTE: begin
                  if (act == ACT_RDBYTE) begin
                     rx_valid <= 1'b1;
                     rx_data <= ctl_rdata;
                     rem_q <= rem_dec;
                     sent_q <= 1'b1;
                  end
                  ctrl_q <= ctrl_rd;
                  ctl_cmd_valid <= 1'b1;
                  ctl_cmd <= ctrl_rd;
               end
               ACT_RDLAST, ACT_STOP_OK, ACT_STOP_NODEV, ACT_STOP_IO: begin
                  if (act == ACT_RDLAST) begin
                     rx_valid <= 1'b1;
                     rx_data <= ctl_rdata;
                  end
                  ctl_cmd_valid <= 1'b1;
                  ctl_cmd <= ctrl_stop;
                  ctrl_q <= ctrl_q & ~M_INTEN;
                  busy_q <= 1'b0;
                  done <= 1'b1;
                  ctl_reinit <= (act == ACT_STOP_IO);
                  err_q <= (act == ACT_STOP_NODEV) ? ERR_NODEV :
                           (act == ACT_STOP_IO)    ? ERR_IO : ERR_NONE;
               end
               ACT_STOP_IDLE: begin
                  ctl_cmd_valid <= 1'b1;
                  ctl_cmd <= ctrl_stop;
                  ctrl_q <= ctrl_q & ~M_INTEN;
               end
               default: ;
            endcase
         end
      end
   end

   assign busy = busy_q;
   assign err  = err_q;

   // R5: every STOP control write has interrupt-enable cleared
   a_r5_stop_no_inten: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_cmd_valid && ctl_cmd[CB_STOP]) |-> !ctl_cmd[CB_INTEN]);
   // R3: START only follows an accepted go
   a_r3_start_after_go: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_cmd_valid && ctl_cmd[CB_START]) |-> ($past(go) && !$past(busy_q)));
   // R11: reinit only with an I/O error completion
   a_r11_reinit_io: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_reinit |-> (done && err == ERR_IO));
   // R13: events after a latched error produce no command
   a_r13_err_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && err_q != ERR_NONE && evt && !go) |=> !ctl_cmd_valid);
   // R8: a received byte is never accompanied by a data-register load
   a_r8_rx_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_valid, ctl_dat_we}));
   // R9: completion leaves the sequencer idle
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/tb_i2c_msg_sequencer.sv
`timescale 1ns/1ps
module tb_i2c_msg_sequencer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       go = 1'b0;
   logic [9:0] msg_addr = '0;
   logic       msg_ten = 1'b0, msg_rd = 1'b0;
   logic [7:0] msg_len = '0;
   logic       abort_req = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_take, rx_valid;
   logic [7:0] rx_data;
   logic       ctl_iflag = 1'b0;
   logic [7:0] ctl_status = '0, ctl_rdata = '0;
   logic       ctl_cmd_valid, ctl_dat_we, ctl_reinit, busy, done;
   logic [7:0] ctl_cmd, ctl_dat;
   logic [1:0] err;

   int n_cmp = 0, n_bad = 0, cyc = 0;

   always #4 clk = ~clk;

   i2c_msg_sequencer dut (
      .clk(clk), .rst_n(rst_n), .go(go), .msg_addr(msg_addr),
      .msg_ten(msg_ten), .msg_rd(msg_rd), .msg_len(msg_len),
      .abort_req(abort_req), .tx_data(tx_data), .tx_take(tx_take),
      .rx_data(rx_data), .rx_valid(rx_valid), .ctl_iflag(ctl_iflag),
      .ctl_status(ctl_status), .ctl_rdata(ctl_rdata),
      .ctl_cmd_valid(ctl_cmd_valid), .ctl_cmd(ctl_cmd),
      .ctl_dat_we(ctl_dat_we), .ctl_dat(ctl_dat), .ctl_reinit(ctl_reinit),
      .busy(busy), .done(done), .err(err)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
      n_cmp++;
      if (a !== e) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, a, e);
      end
   endtask

   task automatic start_msg(input logic [9:0] a, input logic ten, input logic rd,
                            input logic [7:0] len);
      @(negedge clk);
      msg_addr = a; msg_ten = ten; msg_rd = rd; msg_len = len; go = 1'b1;
      @(posedge clk); @(negedge clk);
      go = 1'b0;
   endtask

   task automatic fire(input logic [7:0] st, input logic [7:0] rd);
      @(negedge clk);
      ctl_status = st; ctl_rdata = rd; ctl_iflag = 1'b1;
      @(posedge clk); @(negedge clk);
      ctl_iflag = 1'b0;
   endtask

   task automatic pulse_abort();
      @(negedge clk); abort_req = 1'b1;
      @(negedge clk); abort_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R3 reset busy", busy, 0);
      chk("R3 reset cmd", ctl_cmd_valid, 0);
      chk("R3 reset err", err, 0);
   endtask

   task automatic t_write7();
      start_msg(10'h05A, 1'b0, 1'b0, 8'd2);
      chk("R3 start cmd", {ctl_cmd_valid, ctl_cmd}, {1'b1, 8'hE4});
      chk("R3 busy", busy, 1);
      fire(8'h08, 8'h00);
      chk("R1 addr byte", {ctl_dat_we, ctl_dat}, {1'b1, 8'hB4});
      chk("R1 addr cmd", {ctl_cmd_valid, ctl_cmd}, {1'b1, 8'hE4 & ~8'h20});
      tx_data = 8'h11;
      fire(8'h18, 8'h00);
      chk("R4 byte1", {tx_take, ctl_dat_we, ctl_dat}, {2'b11, 8'h11});
      chk("R4 cmd", ctl_cmd, 8'hC4);
      tx_data = 8'h22;
      fire(8'h28, 8'h00);
      chk("R4 byte2", {tx_take, ctl_dat}, {1'b1, 8'h22});
      fire(8'h28, 8'h00);
      chk("R5 stop cmd", {ctl_cmd_valid, ctl_cmd, tx_take}, {1'b1, 8'h54, 1'b0});
      chk("R5 done", {done, err, busy}, {1'b1, 2'd0, 1'b0});
   endtask

   task automatic t_idle_event();
      fire(8'h28, 8'h00);
      chk("R12 idle stop", {ctl_cmd_valid, ctl_cmd}, {1'b1, 8'h54});
      chk("R12 no done", {done, busy}, 2'b00);
   endtask

   task automatic t_read10();
      start_msg(10'h2A5, 1'b1, 1'b1, 8'd3);
      fire(8'h08, 8'h00);
      chk("R2 first byte", ctl_dat, 8'hF5);
      fire(8'h40, 8'h00);
      chk("R2 second byte", {ctl_dat_we, ctl_dat}, {1'b1, 8'hA5});
      fire(8'hE0, 8'h00);
      chk("R8 continue", {ctl_cmd_valid, ctl_cmd, rx_valid}, {1'b1, 8'hC4, 1'b0});
      fire(8'h50, 8'h31);
      chk("R8 rx1", {rx_valid, rx_data, ctl_cmd}, {1'b1, 8'h31, 8'hC4});
      fire(8'h50, 8'h32);
      chk("R8 rx2 ack dropped", {rx_valid, rx_data, ctl_cmd}, {1'b1, 8'h32, 8'hC0});
      fire(8'h58, 8'h33);
      chk("R9 last byte", {rx_valid, rx_data}, {1'b1, 8'h33});
      chk("R9 stop", {ctl_cmd_valid, ctl_cmd, done, err}, {1'b1, 8'h50, 1'b1, 2'd0});
   endtask

   task automatic t_probe();
      start_msg(10'h050, 1'b0, 1'b1, 8'd0);
      fire(8'h08, 8'h00);
      chk("R1 read addr", ctl_dat, 8'hA1);
      fire(8'h40, 8'h00);
      chk("R7 probe stop", {ctl_cmd_valid, ctl_cmd, rx_valid}, {1'b1, 8'h54, 1'b0});
      chk("R7 probe done", {done, err}, {1'b1, 2'd0});
   endtask

   task automatic t_nodev();
      start_msg(10'h033, 1'b0, 1'b0, 8'd1);
      fire(8'h08, 8'h00);
      fire(8'h20, 8'h00);
      chk("R10 nodev stop", {ctl_cmd_valid, ctl_cmd}, {1'b1, 8'h54});
      chk("R10 nodev err", {done, err, ctl_reinit}, {1'b1, 2'd1, 1'b0});
      fire(8'h08, 8'h00);
      chk("R13 ignored after error", {ctl_cmd_valid, ctl_dat_we}, 2'b00);
      chk("R13 err kept", err, 2'd1);
   endtask

   task automatic t_ioerr();
      start_msg(10'h011, 1'b0, 1'b1, 8'd2);
      chk("R13 go clears err", err, 2'd0);
      fire(8'h08, 8'h00);
      chk("R1 addr", ctl_dat, 8'h23);
      fire(8'h38, 8'h00);
      chk("R11 io stop", {ctl_cmd_valid, ctl_cmd, ctl_reinit}, {1'b1, 8'h54, 1'b1});
      chk("R11 io err", {done, err}, {1'b1, 2'd2});
   endtask

   task automatic t_abort_write();
      int pulses = 0;
      start_msg(10'h044, 1'b0, 1'b0, 8'd3);
      // R13: hold the flag high for several cycles, expect one action
      @(negedge clk);
      ctl_status = 8'h08; ctl_iflag = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); @(negedge clk);
         if (ctl_cmd_valid) pulses++;
      end
      ctl_iflag = 1'b0;
      chk("R13 single action", pulses, 1);
      pulse_abort();
      tx_data = 8'h5C;
      fire(8'h18, 8'h00);
      chk("R6 first byte sent despite abort", {tx_take, ctl_dat}, {1'b1, 8'h5C});
      fire(8'h28, 8'h00);
      chk("R6 abort stop", {ctl_cmd_valid, ctl_cmd, tx_take}, {1'b1, 8'h54, 1'b0});
      chk("R6 done", {done, err}, {1'b1, 2'd0});
   endtask

   task automatic t_abort_read();
      start_msg(10'h03C, 1'b0, 1'b1, 8'd3);
      fire(8'h08, 8'h00);
      chk("R1 addr", ctl_dat, 8'h79);
      pulse_abort();
      fire(8'h40, 8'h00);
      chk("R14 ack dropped", {ctl_cmd_valid, ctl_cmd}, {1'b1, 8'hC0});
      fire(8'h58, 8'h77);
      chk("R14 final", {rx_valid, rx_data, ctl_cmd, done}, {1'b1, 8'h77, 8'h50, 1'b1});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_write7();
      t_idle_event();
      t_read10();
      t_probe();
      t_nodev();
      t_ioerr();
      t_abort_write();
      t_abort_read();
      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule